// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible register file of a simple LCD controller. A host reaches it over a 32-bit request bus. It holds a control word, three timing words and a subpanel word, returns a read-only status word, and drives one level-sensitive interrupt line. The control word carries the panel load mode, the TFT and monochrome selects, a two-bit interrupt mask and the enable bit. Read-back ORs fixed one-bits into several words. Width and height are written and held as the count minus one.

A separate fetch sequencer reports three events: frame done, palette done and sync error. They arrive as single-cycle pulses and set sticky status flags. When software flips the enable bit, the block sends the sequencer a one-cycle toggle pulse. The block then updates the flags for that edge of the enable bit. A sync error clears the enable bit on its own. The block does not fetch pixels or generate panel timing. It stores the timing values and returns them.

Top module: `lcdr_regs`

## Requirements
- R1: After reset these reads return: control 0xFE000C34, timing0 0x0000000F, timing1 0x00000000, timing2 0xFC000000, status 0 and subpanel 0. After reset the interrupt, the enable output and the load-mode output are all low.
- R2: Control (offset 0x00) stores load mode from bits 21:20, TFT from bit 7, the interrupt mask from bits 4:3, monochrome from bit 1 and enable from bit 0. It also keeps the written bits under mask 0x01CFF300. A read returns these fields in the same positions, with TFT also copied to bit 23, all ORed with 0xFE000C34.
- R3: Timing0 (0x04) and timing1 (0x08) store a full 32-bit word. Bits 9:0 hold width minus one and height minus one respectively. A timing0 read has bits 3:0 forced to 1. A timing1 read returns the word unchanged.
- R4: Timing2 (0x0C) stores the full word and reads back with bits 31:26 forced to 1.
- R5: Status (0x10) is read-only. A write to it changes nothing. It reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero.
- R6: Subpanel (0x14) stores only the written bits under mask 0xA1FFFFFF.
- R7: A read request returns its data on rdata_o with rvalid_o high in the cycle after the request. A write request never raises rvalid_o.
- R8: An access to any other offset, including an unaligned one, changes no register. A read of such an offset returns zero. err_o pulses for one cycle after the request. A valid access leaves err_o low.
- R9: en_toggle_o pulses for one cycle after a control write, but only when the written bit 0 differs from the current enable state.
- R10: Event pulses set the frame-done, palette-done and sync-error flags. These flags stay set. When enable goes from 0 to 1, frame-done and palette-done clear. When enable goes from 1 to 0, sync-error clears and frame-done is set, unless the load mode is 1. These edge updates show in status two cycles after the write.
- R11: irq_o is high when frame-done is set with mask bit 0 (control bit 3) set, or palette-done is set with mask bit 1 (control bit 4) set, or sync-error is set, whatever the mask. Otherwise it is low.
- R12: A sync-error event clears the enable state in the next cycle and produces no toggle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid pulse |
| err_o | output | 1 | Undefined-offset pulse |
| frame_done_i | input | 1 | Frame-done event from the sequencer |
| palette_done_i | input | 1 | Palette-done event from the sequencer |
| sync_err_i | input | 1 | Sync-error event from the sequencer |
| irq_o | output | 1 | Level interrupt |
| enable_o | output | 1 | Current enable state |
| en_toggle_o | output | 1 | One-cycle enable-change pulse |
| load_mode_o | output | 2 | Panel load mode |

## Verification
A register write takes effect at the clock edge that accepts it. Read data, rvalid_o, err_o and en_toggle_o are due one cycle after the request. A flag set by an event pulse, and the interrupt level that follows from it, appear after the edge that takes the pulse. Flag updates caused by an enable edge need one more edge after the toggle pulse. For that reason the bench waits one idle cycle before it reads status. Every bench task drives inputs on the falling edge and samples on the next falling edge after the relevant rising edge, so each check lands in exactly the cycle these latencies predict.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

    localparam int unsigned DW   = 32;
    localparam int unsigned SZ_W = 10;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_T0   = 8'h04;
    localparam logic [7:0] OFF_T1   = 8'h08;
    localparam logic [7:0] OFF_T2   = 8'h0C;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_SUBP = 8'h14;

    localparam logic [DW-1:0] CTRL_KEEP = 32'h01CF_F300;
    localparam logic [DW-1:0] CTRL_ONES = 32'hFE00_0C34;
    localparam logic [DW-1:0] T0_ONES   = 32'h0000_000F;
    localparam logic [DW-1:0] T2_ONES   = 32'hFC00_0000;
    localparam logic [DW-1:0] SUBP_KEEP = 32'hA1FF_FFFF;

    typedef enum logic [2:0] {
        SEL_CTRL, SEL_T0, SEL_T1, SEL_T2, SEL_STAT, SEL_SUBP, SEL_NONE
    } sel_e;

    typedef struct packed {
        logic [1:0]         load_mode;
        logic               tft;
        logic [1:0]         irq_mask;
        logic               mono;
        logic               enable;
        logic [DW-1:0]      ctrl_misc;
        logic [SZ_W-1:0]    width_m1;
        logic [DW-SZ_W-1:0] t0_hi;
        logic [SZ_W-1:0]    height_m1;
        logic [DW-SZ_W-1:0] t1_hi;
        logic [DW-1:0]      t2;
        logic [DW-1:0]      subpanel;
    } cfg_t;

    typedef struct packed {
        logic fd;
        logic pd;
        logic se;
    } flags_t;

    function automatic sel_e decode(input logic [7:0] a);
        case (a)
            OFF_CTRL: return SEL_CTRL;
            OFF_T0:   return SEL_T0;
            OFF_T1:   return SEL_T1;
            OFF_T2:   return SEL_T2;
            OFF_STAT: return SEL_STAT;
            OFF_SUBP: return SEL_SUBP;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lcdr_cfg.sv
module lcdr_cfg
    import lcdr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  sel_e          sel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          sync_err_i,
    output cfg_t          cfg_o,
    output logic          toggle_o
);

    typedef struct packed {
        cfg_t cfg;
        logic toggle;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.toggle = 1'b0;
        if (wr_i) begin
            case (sel_i)
                SEL_CTRL: begin
                    st_d.cfg.load_mode = wdata_i[21:20];
                    st_d.cfg.tft       = wdata_i[7];
                    st_d.cfg.irq_mask  = wdata_i[4:3];
                    st_d.cfg.mono      = wdata_i[1];
                    st_d.cfg.ctrl_misc = wdata_i & CTRL_KEEP;
                    if (wdata_i[0] != st_q.cfg.enable) begin
                        st_d.cfg.enable = wdata_i[0];
                        st_d.toggle     = 1'b1;
                    end
                end
                SEL_T0: begin
                    st_d.cfg.width_m1 = wdata_i[SZ_W-1:0];
                    st_d.cfg.t0_hi    = wdata_i[DW-1:SZ_W];
                end
                SEL_T1: begin
                    st_d.cfg.height_m1 = wdata_i[SZ_W-1:0];
                    st_d.cfg.t1_hi     = wdata_i[DW-1:SZ_W];
                end
                SEL_T2:   st_d.cfg.t2       = wdata_i;
                SEL_SUBP: st_d.cfg.subpanel = wdata_i & SUBP_KEEP;
                default: ;
            endcase
        end
        if (sync_err_i) begin
            st_d.cfg.enable = 1'b0;
            st_d.toggle     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o    = st_q.cfg;
    assign toggle_o = st_q.toggle;

    a_r9_toggle_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.toggle |-> (st_q.cfg.enable != $past(st_q.cfg.enable)));

    a_r12_sync_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_i |=> (!st_q.cfg.enable && !st_q.toggle));

endmodule

// File: rtl/lcdr_status.sv
module lcdr_status
    import lcdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       toggle_i,
    input  logic       enable_i,
    input  logic [1:0] load_mode_i,
    input  logic [1:0] irq_mask_i,
    input  logic       fd_set_i,
    input  logic       pd_set_i,
    input  logic       se_set_i,
    output flags_t     flags_o,
    output logic       irq_o
);

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (toggle_i) begin
            if (enable_i) begin
                fl_d.fd = 1'b0;
                fl_d.pd = 1'b0;
            end else begin
                fl_d.se = 1'b0;
                if (load_mode_i != 2'd1) fl_d.fd = 1'b1;
            end
        end
        if (fd_set_i) fl_d.fd = 1'b1;
        if (pd_set_i) fl_d.pd = 1'b1;
        if (se_set_i) fl_d.se = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q;
    assign irq_o   = (fl_q.fd & irq_mask_i[0]) | (fl_q.pd & irq_mask_i[1]) | fl_q.se;

    a_r11_sync_forces_irq: assert property (@(posedge clk) disable iff (!rst_n)
        se_set_i |=> irq_o);

    a_r10_enable_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_i && enable_i && !fd_set_i && !pd_set_i) |=> (!fl_q.fd && !fl_q.pd));

endmodule

// File: rtl/lcdr_rdata.sv
module lcdr_rdata
    import lcdr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          rd_i,
    input  sel_e          sel_i,
    input  cfg_t          cfg_i,
    input  flags_t        flags_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic          err_o
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          err;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DW-1:0] word;

    always_comb begin
        word = '0;
        case (sel_i)
            SEL_CTRL: begin
                word        = cfg_i.ctrl_misc | CTRL_ONES;
                word[23]    = word[23] | cfg_i.tft;
                word[21:20] = word[21:20] | cfg_i.load_mode;
                word[7]     = word[7] | cfg_i.tft;
                word[4:3]   = word[4:3] | cfg_i.irq_mask;
                word[1]     = word[1] | cfg_i.mono;
                word[0]     = word[0] | cfg_i.enable;
            end
            SEL_T0:   word = {cfg_i.t0_hi, cfg_i.width_m1} | T0_ONES;
            SEL_T1:   word = {cfg_i.t1_hi, cfg_i.height_m1};
            SEL_T2:   word = cfg_i.t2 | T2_ONES;
            SEL_STAT: begin
                word[6] = flags_i.pd;
                word[2] = flags_i.se;
                word[0] = flags_i.fd;
            end
            SEL_SUBP: word = cfg_i.subpanel;
            default:  word = '0;
        endcase
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = rd_i;
        rd_d.err    = req_i && (sel_i == SEL_NONE);
        if (rd_i) rd_d.rdata = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o  = rd_q.rdata;
    assign rvalid_o = rd_q.rvalid;
    assign err_o    = rd_q.err;

    a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q.rvalid && rd_q.err) |-> (rd_q.rdata == '0));

endmodule

// File: rtl/lcdr_regs.sv
module lcdr_regs
    import lcdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o,
    output logic              err_o,
    input  logic              frame_done_i,
    input  logic              palette_done_i,
    input  logic              sync_err_i,
    output logic              irq_o,
    output logic              enable_o,
    output logic              en_toggle_o,
    output logic [1:0]        load_mode_o
);

    localparam int unsigned LOW_W = 8;

    sel_e   sel;
    cfg_t   cfg;
    flags_t flags;
    logic   toggle;
    logic   wr, rd, hi_zero;

    assign hi_zero = ((addr_i >> LOW_W) == '0);
    assign sel     = hi_zero ? decode(addr_i[LOW_W-1:0]) : SEL_NONE;
    assign wr      = req_i & we_i;
    assign rd      = req_i & ~we_i;

    lcdr_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr),
        .sel_i      (sel),
        .wdata_i    (wdata_i),
        .sync_err_i (sync_err_i),
        .cfg_o      (cfg),
        .toggle_o   (toggle)
    );

    lcdr_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .toggle_i    (toggle),
        .enable_i    (cfg.enable),
        .load_mode_i (cfg.load_mode),
        .irq_mask_i  (cfg.irq_mask),
        .fd_set_i    (frame_done_i),
        .pd_set_i    (palette_done_i),
        .se_set_i    (sync_err_i),
        .flags_o     (flags),
        .irq_o       (irq_o)
    );

    lcdr_rdata u_rdata (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .rd_i     (rd),
        .sel_i    (sel),
        .cfg_i    (cfg),
        .flags_i  (flags),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .err_o    (err_o)
    );

    assign enable_o    = cfg.enable;
    assign en_toggle_o = toggle;
    assign load_mode_o = cfg.load_mode;

    a_r7_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(req_i && !we_i));

    a_r8_err_after_bad_offset: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_i && ((addr_i[1:0] != 2'b00) || (addr_i > ADDR_W'(8'h14)))));

endmodule

// File: tb/tb_lcdr_regs.sv
module tb_lcdr_regs;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0, we_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              rvalid_o, err_o, irq_o, enable_o, en_toggle_o;
    logic [1:0]        load_mode_o;
    logic              fd_i = 1'b0, pd_i = 1'b0, se_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] rd_val;
    logic        rd_err, rd_vld, wr_tog, wr_err, wr_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdr_regs #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o),
        .frame_done_i(fd_i), .palette_done_i(pd_i), .sync_err_i(se_i),
        .irq_o(irq_o), .enable_o(enable_o), .en_toggle_o(en_toggle_o),
        .load_mode_o(load_mode_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl(input logic [31:0] w, input logic en);
        logic [31:0] r;
        r = (w & 32'h01CF_F300) | 32'hFE00_0C34;
        r = r | ({31'd0, w[7]} << 23) | ({30'd0, w[21:20]} << 20) | ({31'd0, w[7]} << 7)
              | ({30'd0, w[4:3]} << 3) | ({31'd0, w[1]} << 1) | {31'd0, en};
        return r;
    endfunction

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); @(negedge clk);
        wr_tog = en_toggle_o; wr_err = err_o; wr_vld = rvalid_o;
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        @(posedge clk); @(negedge clk);
        rd_val = rdata_o; rd_err = err_o; rd_vld = rvalid_o;
        req_i = 1'b0;
    endtask

    task automatic pulse_evt(input logic f, input logic p, input logic s);
        fd_i = f; pd_i = p; se_i = s;
        @(posedge clk); @(negedge clk);
        fd_i = 1'b0; pd_i = 1'b0; se_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 enable", {31'd0, enable_o}, 32'd0);
        chk("R1 load mode", {30'd0, load_mode_o}, 32'd0);
        bus_rd(8'h00); chk("R1 ctrl", rd_val, 32'hFE00_0C34);
        bus_rd(8'h04); chk("R1 timing0", rd_val, 32'h0000_000F);
        bus_rd(8'h08); chk("R1 timing1", rd_val, 32'h0);
        bus_rd(8'h0C); chk("R1 timing2", rd_val, 32'hFC00_0000);
        bus_rd(8'h10); chk("R1 status", rd_val, 32'h0);
        bus_rd(8'h14); chk("R1 subpanel", rd_val, 32'h0);
    endtask

    task automatic t_ctrl();
        bus_wr(8'h00, 32'hFFFF_FFFE);
        chk("R2 no toggle", {31'd0, wr_tog}, 32'd0);
        bus_rd(8'h00); chk("R2 ctrl all", rd_val, exp_ctrl(32'hFFFF_FFFE, 1'b0));
        chk("R2 all ones value", rd_val, 32'hFFFF_FFBE);
        bus_wr(8'h00, 32'h0010_0080);
        bus_rd(8'h00); chk("R2 ctrl mode1 tft", rd_val, 32'hFE90_0CB4);
        chk("R2 load mode out", {30'd0, load_mode_o}, 32'd1);
        bus_wr(8'h00, 32'h0000_0000);
    endtask

    task automatic t_timing();
        bus_wr(8'h04, 32'hABCD_E123);
        bus_rd(8'h04); chk("R3 timing0", rd_val, 32'hABCD_E12F);
        bus_wr(8'h08, 32'h1234_53FF);
        bus_rd(8'h08); chk("R3 timing1", rd_val, 32'h1234_53FF);
        bus_wr(8'h0C, 32'h0123_4567);
        bus_rd(8'h0C); chk("R4 timing2", rd_val, 32'hFD23_4567);
    endtask

    task automatic t_subpanel();
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_rd(8'h14); chk("R6 subpanel ones", rd_val, 32'hA1FF_FFFF);
        bus_wr(8'h14, 32'h5E00_0000);
        bus_rd(8'h14); chk("R6 subpanel masked", rd_val, 32'h0);
    endtask

    task automatic t_bus();
        bus_rd(8'h04);
        chk("R7 rvalid on read", {31'd0, rd_vld}, 32'd1);
        chk("R8 no err on good read", {31'd0, rd_err}, 32'd0);
        bus_wr(8'h0C, 32'h0000_0001);
        chk("R7 no rvalid on write", {31'd0, wr_vld}, 32'd0);
        chk("R8 no err on good write", {31'd0, wr_err}, 32'd0);
        tick();
        chk("R7 rvalid is a pulse", {31'd0, rvalid_o}, 32'd0);
        bus_rd(8'h18);
        chk("R8 bad read zero", rd_val, 32'h0);
        chk("R8 bad read err", {31'd0, rd_err}, 32'd1);
        tick();
        chk("R8 err one cycle", {31'd0, err_o}, 32'd0);
        bus_rd(8'h02); chk("R8 unaligned err", {31'd0, rd_err}, 32'd1);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        chk("R8 bad write err", {31'd0, wr_err}, 32'd1);
        bus_wr(8'h01, 32'hFFFF_FFFF);
        bus_rd(8'h00); chk("R8 ctrl untouched", rd_val, 32'hFE00_0C34);
        bus_rd(8'h0C); chk("R8 timing2 untouched", rd_val, 32'hFC00_0001);
    endtask

    task automatic t_status_irq();
        bus_wr(8'h00, 32'h0000_0008);
        pulse_evt(1'b1, 1'b0, 1'b0);
        chk("R11 fd with mask0", {31'd0, irq_o}, 32'd1);
        bus_wr(8'h10, 32'h0000_0000);
        bus_rd(8'h10); chk("R5 status write ignored", rd_val, 32'h0000_0001);
        bus_wr(8'h00, 32'h0000_0000);
        chk("R11 fd masked", {31'd0, irq_o}, 32'd0);
        pulse_evt(1'b0, 1'b1, 1'b0);
        chk("R11 pd masked", {31'd0, irq_o}, 32'd0);
        bus_rd(8'h10); chk("R5 status layout", rd_val, 32'h0000_0041);
        bus_wr(8'h00, 32'h0000_0010);
        chk("R11 pd with mask1", {31'd0, irq_o}, 32'd1);
        bus_wr(8'h00, 32'h0000_0000);
    endtask

    task automatic t_enable();
        bus_wr(8'h00, 32'h0000_0001);
        chk("R9 toggle on rise", {31'd0, wr_tog}, 32'd1);
        chk("R9 enable high", {31'd0, enable_o}, 32'd1);
        tick();
        chk("R9 toggle one cycle", {31'd0, en_toggle_o}, 32'd0);
        bus_rd(8'h10); chk("R10 rise clears fd pd", rd_val, 32'h0);
        bus_wr(8'h00, 32'h0000_0001);
        chk("R9 no toggle same bit", {31'd0, wr_tog}, 32'd0);
        pulse_evt(1'b0, 1'b0, 1'b1);
        chk("R12 sync clears enable", {31'd0, enable_o}, 32'd0);
        chk("R12 no toggle", {31'd0, en_toggle_o}, 32'd0);
        chk("R11 sync ignores mask", {31'd0, irq_o}, 32'd1);
        bus_wr(8'h00, 32'h0000_0001);
        chk("R9 toggle after sync", {31'd0, wr_tog}, 32'd1);
        tick();
        bus_rd(8'h10); chk("R10 rise keeps se", rd_val, 32'h0000_0004);
        bus_wr(8'h00, 32'h0000_0000);
        chk("R9 toggle on fall", {31'd0, wr_tog}, 32'd1);
        tick();
        bus_rd(8'h10); chk("R10 fall sets fd clears se", rd_val, 32'h0000_0001);
        chk("R11 irq low after fall", {31'd0, irq_o}, 32'd0);
        bus_wr(8'h00, 32'h0010_0001);
        tick();
        bus_wr(8'h00, 32'h0010_0000);
        tick();
        bus_rd(8'h10); chk("R10 mode1 fall no fd", rd_val, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_timing();
        t_subpanel();
        t_bus();
        t_status_irq();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule